// File: doc/BRIEF.md
# SPI Master with Dual FIFOs and Sticky Status

This block is a 16-bit SPI master for use inside a larger chip. Software talks to it through a small register port with four word addresses. One address holds the control settings, one holds a live status word, one is the data port, and one holds the interrupt and error flags. Each data port write queues a word in an 8-deep transmit FIFO. The shift engine pops words from that FIFO, sends them MSB first on the serial data output, and collects the incoming serial bits into an 8-deep receive FIFO. A read of the data port pops the oldest received word.

The serial clock comes from the bus clock through an even divider. The idle level of the serial clock can be set either way, and data can be captured on either the odd or the even clock edges. The select line goes low when the first queued word starts. It stays low across back-to-back words and rises once the transmit FIFO has drained.

A mode bit chooses between two modes. In queued mode the four FIFO-level conditions latch as interrupt flags, and software clears each one by writing a one to it. In single-buffer mode those four bits simply follow the FIFO levels, and a data write is only accepted after a status read that saw the transmit side empty. Separate sticky flags record a lost word on each FIFO, with a second flag for any repeat loss. Clearing the enable bit returns the whole block to its reset state.

Top module: `spi_fifo_master`

## Requirements
- R1: While the enable bit (control bit 0) is 0, select is high, the serial clock sits at the polarity bit (control bit 1), and both FIFOs and all flags are empty or zero. Clearing enable in the middle of a frame returns the block to this state within two cycles.
- R2: Each word is sent MSB first on `mosi_o` while select is low. The 16 bits captured from `miso_i` in the same frame become one receive FIFO entry, and a read of address 2 returns entries in the order they arrived.
- R3: The serial clock toggles once every DIV+1 bus cycles, where DIV is control bits 15:8. A frame has 32 toggles. Select is low for 33·(DIV+1) cycles per word when words run back to back. While select is high the clock holds the polarity level.
- R4: With the phase bit (control bit 2) at 0, the first data bit is valid before the first edge and both sides capture on edges 1, 3, 5 and so on. With the phase bit at 1, the data changes on the odd edges and both sides capture on the even edges.
- R5: Select stays low between words while the transmit FIFO still holds data. It rises exactly once after the last queued word.
- R6: With the queued-mode bit (control bit 3) at 0, a write to address 2 is accepted only if a status read taken while the transmit FIFO was empty came first, with no accepted write in between. Any other write is ignored.
- R7: The status word at address 1 reads as follows. Bit 0 is transmit empty. Bit 1 means 2 or fewer transmit entries. Bit 2 means 8 receive entries. Bit 3 means 6 or more receive entries. Bit 4 means the receive FIFO is not empty. Bit 5 means select is low. Bits 11:8 hold the transmit count and bits 15:12 hold the receive count.
- R8: A data write that finds 8 transmit entries is dropped and sets flag bit 3. A further dropped write while bit 3 is still set also sets flag bit 1.
- R9: A frame that completes with 8 receive entries is dropped and sets flag bit 2. A further such loss while bit 2 is still set also sets flag bit 0. The 8 stored words are kept.
- R10: In queued mode, writing 1 to flag bits 7 (transmit nearly empty), 6 (receive nearly full), 5 (transmit empty) or 4 (receive full) clears that bit, and writing 0 changes nothing. Outside queued mode these four bits follow their levels, and writes to them have no effect.
- R11: In queued mode each of flag bits 7..4 sets when its condition becomes true. `irq_o` is high whenever any flag bit is set.
- R12: Flag bits 3..0 stay set until a 1 is written to them at address 3, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select: 0 control, 1 status, 2 data, 3 flags |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (pops RX at address 2, arms writes at address 1) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for the selected address |
| ss_o | output | 1 | Select, active low |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | Interrupt, OR of all flag bits |

## Verification
A wrong shift-phase or edge-count state shows up within one frame, 33·(DIV+1) cycles. It appears as a corrupted captured word at the slave model or a corrupted word read back from the receive FIFO, or as a wrong select-low length. A wrong FIFO count shows up on the very next status read and on whether a later overflow write is flagged. Flag latching errors appear at the flag register and at `irq_o` within two cycles of the condition or the clear write.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int DW    = 16;
  localparam int DIV_W = 8;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2,
    A_FLAG = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [3:0]       spare;
    logic             fifo_mode;
    logic             cpha;
    logic             cpol;
    logic             en;
  } ctrl_t;

  // flag bit positions
  localparam int FB_TNE  = 7;
  localparam int FB_RNF  = 6;
  localparam int FB_TE   = 5;
  localparam int FB_RF   = 4;
  localparam int FB_TERR = 3;
  localparam int FB_RERR = 2;
  localparam int FB_TOVF = 1;
  localparam int FB_ROVF = 0;
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o,
  output logic          drop_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          full, empty, do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push_i & ~full & ~clr_i;
  assign do_pop  = pop_i & ~empty & ~clr_i;
  assign drop_o  = push_i & full & ~clr_i;
  assign data_o  = mem[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= data_i;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DW    = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tx_valid_i,
  input  logic [DW-1:0]    tx_data_i,
  output logic             tx_pop_o,
  output logic             rx_push_o,
  output logic [DW-1:0]    rx_data_o,
  input  logic             miso_i,
  output logic             ss_o,
  output logic             sclk_o,
  output logic             mosi_o
);
  localparam int LAST = 2 * DW;
  localparam int EW   = $clog2(LAST + 1);

  logic             active_q, phase_q, mosi_q;
  logic [DIV_W-1:0] div_cnt_q;
  logic [EW-1:0]    edge_q;
  logic [DW-1:0]    tx_sh_q, rx_sh_q;
  logic             tick, at_end, load, stop;

  assign tick   = active_q && (div_cnt_q == div_i);
  assign at_end = tick && (edge_q == EW'(LAST));
  assign load   = en_i && tx_valid_i && (!active_q || at_end);
  assign stop   = at_end && !tx_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      phase_q   <= 1'b0;
      mosi_q    <= 1'b0;
      div_cnt_q <= '0;
      edge_q    <= '0;
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
    end else if (!en_i) begin
      active_q  <= 1'b0;
      phase_q   <= 1'b0;
      mosi_q    <= 1'b0;
      div_cnt_q <= '0;
      edge_q    <= '0;
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
    end else if (load) begin
      active_q  <= 1'b1;
      phase_q   <= 1'b0;
      div_cnt_q <= '0;
      edge_q    <= '0;
      mosi_q    <= tx_data_i[DW-1];
      // phase 0 already presents the MSB, so the register holds the rest
      tx_sh_q   <= cpha_i ? tx_data_i : {tx_data_i[DW-2:0], 1'b0};
    end else if (stop) begin
      active_q  <= 1'b0;
      div_cnt_q <= '0;
      edge_q    <= '0;
    end else if (active_q) begin
      if (tick) begin
        div_cnt_q <= '0;
        edge_q    <= edge_q + 1'b1;
        phase_q   <= ~phase_q;
        if (edge_q[0] == cpha_i) begin
          rx_sh_q <= {rx_sh_q[DW-2:0], miso_i};
        end else begin
          mosi_q  <= tx_sh_q[DW-1];
          tx_sh_q <= {tx_sh_q[DW-2:0], 1'b0};
        end
      end else begin
        div_cnt_q <= div_cnt_q + 1'b1;
      end
    end
  end

  assign tx_pop_o  = load;
  assign rx_push_o = at_end;
  assign rx_data_o = rx_sh_q;
  assign ss_o      = ~active_q;
  assign sclk_o    = cpol_i ^ phase_q;
  assign mosi_o    = mosi_q;
endmodule

// File: rtl/spi_irq_flags.sv
module spi_irq_flags #(
  parameter int DEPTH   = 8,
  parameter int CW      = $clog2(DEPTH + 1),
  parameter int TX_LOW  = 2,
  parameter int RX_HIGH = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          fifo_mode_i,
  input  logic [CW-1:0] tx_cnt_i,
  input  logic [CW-1:0] rx_cnt_i,
  input  logic          tx_drop_i,
  input  logic          rx_drop_i,
  input  logic          clr_we_i,
  input  logic [7:0]    clr_bits_i,
  output logic [7:0]    flags_o,
  output logic          irq_o
);
  logic [3:0] cond, cond_prev_q, pend_q, pend_clr;
  logic       terr_q, rerr_q, tovf_q, rovf_q;
  logic [7:0] clr;

  assign cond = {tx_cnt_i <= CW'(TX_LOW), rx_cnt_i >= CW'(RX_HIGH),
                 tx_cnt_i == '0, rx_cnt_i == CW'(DEPTH)};
  assign clr      = clr_we_i ? clr_bits_i : 8'h00;
  assign pend_clr = clr[7:4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_prev_q <= '0;
      pend_q      <= '0;
      terr_q      <= 1'b0;
      rerr_q      <= 1'b0;
      tovf_q      <= 1'b0;
      rovf_q      <= 1'b0;
    end else if (!en_i) begin
      cond_prev_q <= '0;
      pend_q      <= '0;
      terr_q      <= 1'b0;
      rerr_q      <= 1'b0;
      tovf_q      <= 1'b0;
      rovf_q      <= 1'b0;
    end else begin
      cond_prev_q <= cond;
      if (fifo_mode_i) pend_q <= (pend_q & ~pend_clr) | (cond & ~cond_prev_q);
      else             pend_q <= cond;
      // a new loss wins over a simultaneous clear
      terr_q <= (terr_q & ~clr[3]) | tx_drop_i;
      rerr_q <= (rerr_q & ~clr[2]) | rx_drop_i;
      tovf_q <= (tovf_q & ~clr[1]) | (tx_drop_i & terr_q);
      rovf_q <= (rovf_q & ~clr[0]) | (rx_drop_i & rerr_q);
    end
  end

  assign flags_o = {pend_q, terr_q, rerr_q, tovf_q, rovf_q};
  assign irq_o   = |flags_o;
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int TX_LOW  = 2,
  parameter int RX_HIGH = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        ss_o,
  output logic        sclk_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        irq_o
);
  localparam int CW = $clog2(DEPTH + 1);

  ctrl_t         ctrl_q;
  logic          armed_q;
  logic          en_q, cpol_q, cpha_q, fifo_mode_q;
  logic          wr_data, rd_data, wr_ctrl, wr_flag, rd_stat, tx_accept;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [DW-1:0] tx_head, rx_head, rx_word;
  logic          tx_pop, rx_push, tx_drop, rx_drop;
  logic [7:0]    flags;
  logic [15:0]   stat;

  assign en_q        = ctrl_q.en;
  assign cpol_q      = ctrl_q.cpol;
  assign cpha_q      = ctrl_q.cpha;
  assign fifo_mode_q = ctrl_q.fifo_mode;

  assign wr_ctrl   = wr_i && (addr_i == A_CTRL);
  assign wr_data   = wr_i && (addr_i == A_DATA);
  assign wr_flag   = wr_i && (addr_i == A_FLAG);
  assign rd_data   = rd_i && (addr_i == A_DATA);
  assign rd_stat   = rd_i && (addr_i == A_STAT);
  assign tx_accept = wr_data && en_q && (fifo_mode_q || armed_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i);
  end

  // single-buffer handshake: status read with TX empty arms one write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else if (!en_q) armed_q <= 1'b0;
    else if (tx_accept && !fifo_mode_q) armed_q <= 1'b0;
    else if (rd_stat && (tx_cnt == '0)) armed_q <= 1'b1;
  end

  spi_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_tx_fifo (
    .clk_i, .rst_ni, .clr_i(!en_q), .push_i(tx_accept), .data_i(wdata_i),
    .pop_i(tx_pop), .data_o(tx_head), .count_o(tx_cnt), .drop_o(tx_drop)
  );

  spi_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_rx_fifo (
    .clk_i, .rst_ni, .clr_i(!en_q), .push_i(rx_push), .data_i(rx_word),
    .pop_i(rd_data), .data_o(rx_head), .count_o(rx_cnt), .drop_o(rx_drop)
  );

  spi_shift_engine #(.DW(DW), .DIV_W(DIV_W)) u_engine (
    .clk_i, .rst_ni, .en_i(en_q), .cpol_i(cpol_q), .cpha_i(cpha_q),
    .div_i(ctrl_q.div), .tx_valid_i(tx_cnt != '0), .tx_data_i(tx_head),
    .tx_pop_o(tx_pop), .rx_push_o(rx_push), .rx_data_o(rx_word),
    .miso_i, .ss_o, .sclk_o, .mosi_o
  );

  spi_irq_flags #(.DEPTH(DEPTH), .CW(CW), .TX_LOW(TX_LOW), .RX_HIGH(RX_HIGH)) u_flags (
    .clk_i, .rst_ni, .en_i(en_q), .fifo_mode_i(fifo_mode_q),
    .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt), .tx_drop_i(tx_drop), .rx_drop_i(rx_drop),
    .clr_we_i(wr_flag), .clr_bits_i(wdata_i[7:0]), .flags_o(flags), .irq_o
  );

  always_comb begin
    stat        = '0;
    stat[0]     = (tx_cnt == '0);
    stat[1]     = (tx_cnt <= CW'(TX_LOW));
    stat[2]     = (rx_cnt == CW'(DEPTH));
    stat[3]     = (rx_cnt >= CW'(RX_HIGH));
    stat[4]     = (rx_cnt != '0);
    stat[5]     = ~ss_o;
    stat[11:8]  = 4'(tx_cnt);
    stat[15:12] = 4'(rx_cnt);
  end

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      A_CTRL:  rdata_o = ctrl_q;
      A_STAT:  rdata_o = stat;
      A_DATA:  rdata_o = rx_head;
      default: rdata_o = {8'h00, flags};
    endcase
  end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en,
  input logic          cpol,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [7:0]    flags,
  input logic          ss,
  input logic          sclk
);
  p_idle_when_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && $past(!en)) |-> (ss && (sclk == cpol) && tx_cnt == '0 && rx_cnt == '0 && flags == 8'h00));

  p_sclk_quiet_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss && $past(ss) && $stable(cpol)) |-> $stable(sclk));

  p_ss_fall_needs_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ss) |-> ($past(tx_cnt) != '0));

  p_tx_err_on_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[3]) |-> ($past(tx_cnt) == CW'(DEPTH)));

  p_tx_ovf_after_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[1]) |-> $past(flags[3]));

  p_rx_err_on_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[2]) |-> ($past(rx_cnt) == CW'(DEPTH)));

  p_rx_ovf_after_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[0]) |-> $past(flags[2]));
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en(en_q), .cpol(cpol_q),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .flags(flags), .ss(ss_o), .sclk(sclk_o)
);

// File: tb/sim_spi_fifo_master.sv
`timescale 1ns/1ps
module sim_spi_fifo_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic we = 1'b0, re = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic ss, sclk, mosi, irq;
  logic miso = 1'b0;

  always #2.5 clk = ~clk;

  spi_fifo_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(we), .rd_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .ss_o(ss), .sclk_o(sclk),
    .mosi_o(mosi), .miso_i(miso), .irq_o(irq)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // slave model
  logic [15:0] sl_words [64];
  logic [15:0] mo_words [64];
  int sl_idx = 0, mo_idx = 0, e_n = 0;
  logic [15:0] sl_sh = '0, mo_sh = '0;
  logic cpha_b = 1'b0;

  always @(negedge ss) begin
    e_n = 0;
    sl_sh = sl_words[sl_idx];
    if (!cpha_b) miso = sl_sh[15];
  end

  always @(sclk) begin
    if (ss === 1'b0) begin
      e_n++;
      if (((e_n % 2) == 1) ^ cpha_b) mo_sh = {mo_sh[14:0], mosi};
      else if (cpha_b) begin
        miso = sl_sh[15];
        sl_sh = {sl_sh[14:0], 1'b0};
      end else begin
        sl_sh = {sl_sh[14:0], 1'b0};
        miso = sl_sh[15];
      end
      if (e_n == 32) begin
        mo_words[mo_idx] = mo_sh;
        mo_idx++;
        sl_idx++;
        e_n = 0;
        sl_sh = sl_words[sl_idx];
        if (!cpha_b) miso = sl_sh[15];
      end
    end
  end

  int ss_low_cyc = 0, sclk_edges = 0, ss_rises = 0;
  always @(posedge clk) if (ss === 1'b0) ss_low_cyc++;
  always @(sclk) if (ss === 1'b0) sclk_edges++;
  always @(posedge ss) ss_rises++;

  task automatic clear_counts();
    ss_low_cyc = 0; sclk_edges = 0; ss_rises = 0; sl_idx = 0; mo_idx = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic cfg(input bit en, input bit cpol, input bit cpha, input bit fm, input int div);
    cpha_b = cpha;
    wr(2'd0, {8'(div), 4'h0, fm, cpha, cpol, en});
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd1, s);
      if (s[0] && !s[5]) break;
    end
  endtask

  function automatic logic [15:0] exp_stat(input int txc, input int rxc, input bit busy);
    logic [15:0] s = '0;
    s[0] = (txc == 0); s[1] = (txc <= 2); s[2] = (rxc == 8); s[3] = (rxc >= 6);
    s[4] = (rxc != 0); s[5] = busy; s[11:8] = 4'(txc); s[15:12] = 4'(rxc);
    return s;
  endfunction

  function automatic int exp_low_cycles(input int nwords, input int div);
    return 33 * (div + 1) * nwords;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R2 watchdog act=running exp=done");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] r;
    logic [15:0] txw [16];
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) sl_words[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 ss", {31'd0, ss}, 32'd1);
    chk("R1 sclk", {31'd0, sclk}, 32'd0);
    chk("R11 irq", {31'd0, irq}, 32'd0);
    rd(2'd1, r); chk("R7 stat reset", {16'd0, r}, {16'd0, exp_stat(0, 0, 0)});
    rd(2'd3, r); chk("R1 flags reset", {16'd0, r}, 32'd0);

    // random frames over all clock formats
    for (int it = 0; it < 8; it++) begin
      bit cp, ch; int dv, n;
      cp = 1'($urandom); ch = 1'($urandom);
      dv = int'($urandom % 4); n = 1 + int'($urandom % 4);
      cfg(0, cp, ch, 1, dv);
      cfg(1, cp, ch, 1, dv);
      clear_counts();
      for (int k = 0; k < 16; k++) sl_words[k] = 16'($urandom);
      for (int k = 0; k < n; k++) begin
        txw[k] = 16'($urandom);
        wr(2'd2, txw[k]);
      end
      wait_idle();
      repeat (2) @(negedge clk);
      chk("R2 frames sent", mo_idx, n);
      for (int k = 0; k < n; k++) begin
        chk(ch ? "R4 mosi cpha1" : "R4 mosi cpha0", {16'd0, mo_words[k]}, {16'd0, txw[k]});
        rd(2'd2, r);
        chk("R2 rx word", {16'd0, r}, {16'd0, sl_words[k]});
      end
      chk("R3 ss low cycles", ss_low_cyc, exp_low_cycles(n, dv));
      chk("R3 sclk edges", sclk_edges, 32 * n);
      chk("R5 single ss rise", ss_rises, 1);
      chk("R3 idle level", {31'd0, sclk}, {31'd0, cp});
      rd(2'd1, r); chk("R7 stat drained", {16'd0, r}, {16'd0, exp_stat(0, 0, 0)});
    end

    // R10 R11 queued-mode flag latching
    cfg(0, 0, 0, 0, 0);
    cfg(1, 0, 0, 1, 0);
    rd(2'd3, r); chk("R11 latched on enable", {16'd0, r}, 32'h00A0);
    chk("R11 irq high", {31'd0, irq}, 32'd1);
    wr(2'd3, 16'h0000);
    rd(2'd3, r); chk("R10 zero write no effect", {16'd0, r}, 32'h00A0);
    wr(2'd3, 16'h0020);
    rd(2'd3, r); chk("R10 clear te", {16'd0, r}, 32'h0080);
    wr(2'd3, 16'h0080);
    rd(2'd3, r); chk("R10 clear tne", {16'd0, r}, 32'h0000);
    chk("R11 irq low", {31'd0, irq}, 32'd0);

    // level mode ignores clears
    cfg(0, 0, 0, 0, 0);
    cfg(1, 0, 0, 0, 0);
    wr(2'd3, 16'h00F0);
    rd(2'd3, r); chk("R10 level mode clear ignored", {16'd0, r}, 32'h00A0);

    // R7 R8 R9 R12 overflow sequence
    cfg(0, 0, 0, 0, 0);
    cfg(1, 0, 0, 1, 0);
    clear_counts();
    for (int k = 0; k < 16; k++) begin
      sl_words[k] = 16'($urandom);
      txw[k] = 16'($urandom);
    end
    for (int k = 0; k < 3; k++) wr(2'd2, txw[k]);
    rd(2'd1, r); chk("R7 near empty", {16'd0, r}, {16'd0, exp_stat(2, 0, 1)});
    for (int k = 3; k < 11; k++) wr(2'd2, txw[k]);
    rd(2'd1, r); chk("R7 tx full", {16'd0, r}, {16'd0, exp_stat(8, 0, 1)});
    rd(2'd3, r); chk("R8 err and ovf", {16'd0, r}, 32'h00AA);
    wr(2'd3, 16'h000A);
    rd(2'd3, r); chk("R12 clear err bits", {16'd0, r}, 32'h00A0);
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R8 dropped words not sent", mo_idx, 9);
    chk("R8 ninth word", {16'd0, mo_words[8]}, {16'd0, txw[8]});
    rd(2'd1, r); chk("R7 rx full", {16'd0, r}, {16'd0, exp_stat(0, 8, 0)});
    rd(2'd3, r); chk("R9 rx err", {16'd0, r}, 32'h00F4);
    wr(2'd2, 16'h1234);
    wait_idle();
    rd(2'd3, r); chk("R9 rx ovf", {16'd0, r}, 32'h00F5);
    for (int k = 0; k < 8; k++) begin
      rd(2'd2, r); chk("R9 kept word", {16'd0, r}, {16'd0, sl_words[k]});
    end
    wr(2'd3, 16'h0005);
    rd(2'd3, r); chk("R12 rx err cleared", {16'd0, r} & 32'h000F, 32'h0000);

    // R6 single-buffer handshake
    cfg(0, 0, 1, 0, 0);
    cfg(1, 0, 1, 0, 0);
    clear_counts();
    wr(2'd2, 16'hBEEF);
    repeat (4) @(negedge clk);
    chk("R6 unarmed write ignored ss", {31'd0, ss}, 32'd1);
    rd(2'd1, r); chk("R6 unarmed write ignored stat", {16'd0, r}, {16'd0, exp_stat(0, 0, 0)});
    wr(2'd2, 16'hC35A);
    wr(2'd2, 16'h0F0F);
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R6 one frame", mo_idx, 1);
    chk("R6 armed word", {16'd0, mo_words[0]}, 32'h0000C35A);

    // R1 disable mid-frame
    cfg(0, 1, 0, 1, 3);
    cfg(1, 1, 0, 1, 3);
    wr(2'd2, 16'hAAAA);
    wr(2'd2, 16'h5555);
    repeat (20) @(negedge clk);
    cfg(0, 1, 0, 1, 3);
    repeat (2) @(negedge clk);
    chk("R1 ss off", {31'd0, ss}, 32'd1);
    chk("R1 sclk at cpol", {31'd0, sclk}, 32'd1);
    chk("R1 irq off", {31'd0, irq}, 32'd0);
    rd(2'd1, r); chk("R1 fifos empty", {16'd0, r}, {16'd0, exp_stat(0, 0, 0)});
    rd(2'd3, r); chk("R1 flags clear", {16'd0, r}, 32'd0);

    summary();
    $finish;
  end
endmodule